// File: doc/BRIEF.md
# Stereo PCM Serial Transmitter

This block turns stereo sample pairs into a serial audio stream on one data line. The bit clock and the frame (left/right) clock come from outside. The block watches both clocks with its own system clock and drives each data bit just after the selected launch edge of the bit clock. Both clocks are expected to be synchronous to the system clock already. Each bit-clock phase must last at least two system-clock cycles.

Runtime inputs select the following:
- the sample size (16, 24 or 32 bits);
- one of three placements of the sample in its channel slot: MSB at the slot start, MSB one bit late, or LSB at the slot end;
- the level of the frame clock that marks the left channel;
- the bit-clock edge that launches data.

The slot length is the SLOT_BITS parameter, and it must be at least 32. A stereo pair is taken over a valid/ready handshake once per frame, at the start of the left slot. If no pair is offered, the frame carries silence and a sticky flag records the miss. The format settings are taken up only at a frame start. While the transmitter is gated off, they are taken up continuously.

Top module: `pcm_serial_tx`

## Requirements
- R1: The word-length code selects the sample size: 0 gives 16 bits, 1 gives 24 bits, 2 gives 32 bits, and the reserved code 3 behaves as 32 bits. A sample is taken from the low bits of its 32-bit input word, and the input bits above the sample size have no effect on the output.
- R2: With `late_msb_i` and `rjust_i` both low, the MSB goes out in the first bit period of the slot. The bits follow MSB first, and every slot bit after the LSB is zero.
- R3: With `late_msb_i` high and `rjust_i` low, the MSB goes out in the second bit period of the slot. The first bit period carries the LSB of the previous channel word when that word fills the whole slot, and carries zero otherwise. The first bit after enabling is zero.
- R4: With `rjust_i` high, the sample LSB falls in the last bit period of the slot and the leading bits are zero. `late_msb_i` is then ignored.
- R5: With `lr_pol_i` low, the left word goes out while the frame clock is low. With `lr_pol_i` high, it goes out while the frame clock is high.
- R6: With `bck_pol_i` low, data changes after a falling bit-clock edge. With `bck_pol_i` high, it changes after a rising edge. `sd_o` changes only in the system cycle that follows a launch edge, or when the transmitter is gated off.
- R7: `s_ready_o` is a one-cycle pulse that is high only at a frame start. Exactly one pair is accepted per frame, its left word goes into the left slot and its right word into the right slot.
- R8: If `s_valid_i` is low at a frame start, the whole frame is zero and `underflow_o` is set. `underflow_o` stays set until reset.
- R9: The transmitter runs only while both `tx_en_i` and `glb_en_i` are high. Otherwise `sd_o` is zero and no pair is accepted. After it is enabled, output begins at the next frame start and the slots before that frame start are zero.
- R10: A change to the format inputs in the middle of a frame leaves the rest of that frame unchanged. The change applies from the next frame start.
- R11: After reset, `sd_o`, `s_ready_o` and `underflow_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bck_i | input | 1 | Received bit clock |
| lrck_i | input | 1 | Received frame (left/right) clock |
| wlen_i | input | 2 | Word-length code |
| late_msb_i | input | 1 | MSB one bit period after the frame-clock edge |
| rjust_i | input | 1 | Sample LSB aligned to the slot end |
| lr_pol_i | input | 1 | Frame-clock level of the left slot |
| bck_pol_i | input | 1 | Launch edge: 0 falling, 1 rising |
| tx_en_i | input | 1 | Transmit enable |
| glb_en_i | input | 1 | Global enable |
| s_valid_i | input | 1 | Stereo pair offered |
| s_ready_o | output | 1 | Pair taken this cycle |
| s_left_i | input | 32 | Left sample, in the low bits |
| s_right_i | input | 32 | Right sample, in the low bits |
| sd_o | output | 1 | Serial data |
| underflow_o | output | 1 | Sticky missed-pair flag |

## Verification
The bench plays the receiver's part: it samples the data line at the non-launch edge and compares each captured slot with a stream it builds from the requirements. It targets the bit that carries over between slots in one-bit-late mode with 32-bit words. A design that drops this bit would lose each LSB, and one that leaks it into narrower words would corrupt bit 0 of the slot. It also checks that the right-justified mode overrides the late-MSB flag, that garbage above the sample width stays off the line, and that inverted clock polarities work. A wrong launch edge shows up as every captured slot shifted by one bit. A format change halfway through a frame must not reach the right slot of that frame, and an eager design would send that slot in the new format. Gating by either enable, and a frame with no pair offered, must both give silence and no handshake, and the underflow flag must persist after data returns.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

    localparam int unsigned SAMPLE_W = 32;
    localparam int unsigned IX_W     = $clog2(SAMPLE_W);

    typedef enum logic [1:0] {
        WL_16  = 2'd0,
        WL_24  = 2'd1,
        WL_32  = 2'd2,
        WL_RSV = 2'd3
    } wlen_e;

    typedef struct packed {
        wlen_e wlen;
        logic  late_msb;
        logic  rjust;
        logic  lr_pol;
        logic  bck_pol;
    } txfmt_t;

    function automatic int unsigned word_bits(wlen_e code);
        case (code)
            WL_16:   return 16;
            WL_24:   return 24;
            default: return 32;
        endcase
    endfunction

    // Bit that belongs at slot position pos for the given format.
    function automatic logic slot_bit(txfmt_t f, logic [SAMPLE_W-1:0] w,
                                      int unsigned pos, int unsigned slot,
                                      logic carry);
        int unsigned n;
        logic [IX_W-1:0] ix;
        logic b;
        n  = word_bits(f.wlen);
        b  = 1'b0;
        ix = '0;
        if (f.rjust) begin
            if (pos + n >= slot) begin
                ix = IX_W'(slot - 1 - pos);
                b  = w[ix];
            end
        end else if (f.late_msb) begin
            if (pos == 0) begin
                b = carry;
            end else if (pos <= n) begin
                ix = IX_W'(n - pos);
                b  = w[ix];
            end
        end else if (pos < n) begin
            ix = IX_W'(n - 1 - pos);
            b  = w[ix];
        end
        return b;
    endfunction

endpackage

// File: rtl/pcm_tx_clk_track.sv
module pcm_tx_clk_track #(
    parameter int unsigned SLOT_BITS = 32,
    localparam int unsigned POS_W = $clog2(SLOT_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bck_i,
    input  logic             lrck_i,
    input  logic             bck_pol_i,
    input  logic             lr_pol_i,
    output logic             launch_o,
    output logic             slot_start_o,
    output logic             frame_start_o,
    output logic             left_o,
    output logic [POS_W-1:0] pos_o
);

    localparam logic [POS_W-1:0] POS_LAST = POS_W'(SLOT_BITS - 1);

    logic             bck_q;
    logic             lrck_q;
    logic [POS_W-1:0] pos_q;

    // A launch edge is a bit-clock change that lands on the selected level.
    assign launch_o      = (bck_i != bck_q) && (bck_i == bck_pol_i);
    assign slot_start_o  = launch_o && (lrck_i != lrck_q);
    assign left_o        = (lrck_i == lr_pol_i);
    assign frame_start_o = slot_start_o && left_o;

    always_comb begin
        if (slot_start_o)
            pos_o = '0;
        else if (pos_q == POS_LAST)
            pos_o = pos_q;
        else
            pos_o = pos_q + POS_W'(1);
    end

    always_ff @(posedge clk) begin
        bck_q <= bck_i;
        if (rst) begin
            lrck_q <= 1'b0;
            pos_q  <= POS_LAST;
        end else if (launch_o) begin
            lrck_q <= lrck_i;
            pos_q  <= pos_o;
        end
    end

endmodule

// File: rtl/pcm_tx_pair_buf.sv
module pcm_tx_pair_buf
    import pcm_tx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load_i,
    input  logic                left_i,
    input  logic                valid_i,
    input  logic [SAMPLE_W-1:0] left_w_i,
    input  logic [SAMPLE_W-1:0] right_w_i,
    output logic                ready_o,
    output logic                underflow_o,
    output logic [SAMPLE_W-1:0] word_o
);

    logic [SAMPLE_W-1:0] word_l;
    logic [SAMPLE_W-1:0] word_r;

    assign ready_o = load_i;

    always_comb begin
        if (load_i)
            word_o = valid_i ? left_w_i : '0;
        else
            word_o = left_i ? word_l : word_r;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_l      <= '0;
            word_r      <= '0;
            underflow_o <= 1'b0;
        end else if (load_i) begin
            word_l <= valid_i ? left_w_i  : '0;
            word_r <= valid_i ? right_w_i : '0;
            if (!valid_i)
                underflow_o <= 1'b1;
        end
    end

    AST_UFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
        underflow_o |=> underflow_o); // R8
    AST_UFLOW_ON_MISS: assert property (@(posedge clk) disable iff (rst)
        (load_i && !valid_i) |=> underflow_o); // R8

endmodule

// File: rtl/pcm_tx_shift_out.sv
module pcm_tx_shift_out
    import pcm_tx_pkg::*;
#(
    parameter int unsigned SLOT_BITS = 32,
    localparam int unsigned POS_W = $clog2(SLOT_BITS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run_i,
    input  logic                launch_i,
    input  logic                emit_i,
    input  txfmt_t              fmt_i,
    input  logic [SAMPLE_W-1:0] word_i,
    input  logic [POS_W-1:0]    pos_i,
    output logic                sd_o
);

    logic carry;
    logic next_bit;

    assign next_bit = slot_bit(fmt_i, word_i, 32'(pos_i), SLOT_BITS, carry);

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            sd_o  <= 1'b0;
            carry <= 1'b0;
        end else if (launch_i) begin
            if (emit_i) begin
                sd_o <= next_bit;
                // Last slot bit: remember the LSB that spills into the next slot.
                if (32'(pos_i) == SLOT_BITS - 1)
                    carry <= (word_bits(fmt_i.wlen) == SLOT_BITS) ? word_i[0] : 1'b0;
            end else begin
                sd_o <= 1'b0;
            end
        end
    end

    AST_SD_ON_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (sd_o != $past(sd_o))) |-> ($past(launch_i) || !$past(run_i))); // R6
    AST_SD_GATED: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> !sd_o); // R9

endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx
    import pcm_tx_pkg::*;
#(
    parameter int unsigned SLOT_BITS = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bck_i,
    input  logic        lrck_i,
    input  logic [1:0]  wlen_i,
    input  logic        late_msb_i,
    input  logic        rjust_i,
    input  logic        lr_pol_i,
    input  logic        bck_pol_i,
    input  logic        tx_en_i,
    input  logic        glb_en_i,
    input  logic        s_valid_i,
    output logic        s_ready_o,
    input  logic [31:0] s_left_i,
    input  logic [31:0] s_right_i,
    output logic        sd_o,
    output logic        underflow_o
);

    localparam int unsigned POS_W = $clog2(SLOT_BITS);

    txfmt_t              fmt_in;
    txfmt_t              fmt_act;
    txfmt_t              fmt_now;
    logic                run;
    logic                running;
    logic                launch;
    logic                slot_start;
    logic                frame_start;
    logic                in_left;
    logic                load;
    logic [POS_W-1:0]    pos;
    logic [SAMPLE_W-1:0] word_now;

    assign run = tx_en_i && glb_en_i;

    always_comb begin
        fmt_in.wlen     = wlen_e'(wlen_i);
        fmt_in.late_msb = late_msb_i;
        fmt_in.rjust    = rjust_i;
        fmt_in.lr_pol   = lr_pol_i;
        fmt_in.bck_pol  = bck_pol_i;
    end

    assign load    = run && frame_start;
    assign fmt_now = load ? fmt_in : fmt_act;

    pcm_tx_clk_track #(.SLOT_BITS(SLOT_BITS)) u_track (
        .clk           (clk),
        .rst           (rst),
        .bck_i         (bck_i),
        .lrck_i        (lrck_i),
        .bck_pol_i     (fmt_act.bck_pol),
        .lr_pol_i      (fmt_act.lr_pol),
        .launch_o      (launch),
        .slot_start_o  (slot_start),
        .frame_start_o (frame_start),
        .left_o        (in_left),
        .pos_o         (pos)
    );

    pcm_tx_pair_buf u_buf (
        .clk         (clk),
        .rst         (rst),
        .load_i      (load),
        .left_i      (in_left),
        .valid_i     (s_valid_i),
        .left_w_i    (s_left_i),
        .right_w_i   (s_right_i),
        .ready_o     (s_ready_o),
        .underflow_o (underflow_o),
        .word_o      (word_now)
    );

    pcm_tx_shift_out #(.SLOT_BITS(SLOT_BITS)) u_out (
        .clk      (clk),
        .rst      (rst),
        .run_i    (run),
        .launch_i (launch),
        .emit_i   (running || load),
        .fmt_i    (fmt_now),
        .word_i   (word_now),
        .pos_i    (pos),
        .sd_o     (sd_o)
    );

    // Format is shadowed: it follows the inputs while gated off and is
    // otherwise taken up only at a frame start.
    always_ff @(posedge clk) begin
        if (rst) begin
            fmt_act <= '0;
            running <= 1'b0;
        end else if (!run) begin
            fmt_act <= fmt_in;
            running <= 1'b0;
        end else if (frame_start) begin
            fmt_act <= fmt_in;
            running <= 1'b1;
        end
    end

    AST_READY_GATED: assert property (@(posedge clk) disable iff (rst)
        s_ready_o |-> (tx_en_i && glb_en_i)); // R9
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
        s_ready_o |=> !s_ready_o); // R7
    AST_READY_AT_SLOT: assert property (@(posedge clk) disable iff (rst)
        s_ready_o |-> slot_start); // R7
    AST_FMT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run && !frame_start) |=> $stable(fmt_act)); // R10

endmodule

// File: tb/tb_pcm_serial_tx.sv
module tb_pcm_serial_tx;

    localparam int SLOT = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sck = 1'b1;
    logic        ws = 1'b1;
    logic [1:0]  wlen = 2'd0;
    logic        late = 1'b0;
    logic        rj = 1'b0;
    logic        ws_pol = 1'b0;
    logic        sck_pol = 1'b0;
    logic        tx_en = 1'b0;
    logic        glb_en = 1'b0;
    logic        s_valid = 1'b1;
    logic        s_ready;
    logic [31:0] s_left;
    logic [31:0] s_right;
    logic        sd;
    logic        uflow;

    logic [31:0] lpat [8];
    logic [31:0] rpat [8];
    int          acc = 0;
    int          n_chk = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;

    assign s_left  = lpat[acc % 8];
    assign s_right = rpat[acc % 8];

    always @(posedge clk) if (s_valid && s_ready) acc <= acc + 1;

    pcm_serial_tx dut (
        .clk(clk), .rst(rst), .bck_i(sck), .lrck_i(ws), .wlen_i(wlen),
        .late_msb_i(late), .rjust_i(rj), .lr_pol_i(ws_pol), .bck_pol_i(sck_pol),
        .tx_en_i(tx_en), .glb_en_i(glb_en), .s_valid_i(s_valid), .s_ready_o(s_ready),
        .s_left_i(s_left), .s_right_i(s_right), .sd_o(sd), .underflow_o(uflow)
    );

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run hung, act=running exp=done");
        finish_run();
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic int wbits(logic [1:0] c);
        return (c == 2'd0) ? 16 : (c == 2'd1) ? 24 : 32;
    endfunction

    function automatic logic [31:0] trim(int n, logic [31:0] v);
        logic [63:0] m;
        m = (64'd1 << n) - 64'd1;
        return v & m[31:0];
    endfunction

    function automatic logic [31:0] exp_lj(int n, logic [31:0] v);
        return trim(n, v) << (32 - n);
    endfunction

    function automatic logic [31:0] exp_i2s(int n, logic [31:0] v, logic c);
        logic [31:0] t;
        t = exp_lj(n, v);
        return {c, t[31:1]};
    endfunction

    // Drive one slot; capture sd just before each sampling edge, first bit in MSB.
    task automatic run_slot(input logic wsv, output logic [31:0] cap);
        cap = '0;
        for (int i = 0; i < SLOT; i++) begin
            @(negedge clk);
            sck = sck_pol;
            ws  = wsv;
            repeat (4) @(negedge clk);
            cap = {cap[30:0], sd};
            sck = ~sck_pol;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic setup(logic [1:0] c, logic lt, logic r, logic wp, logic sp);
        tx_en = 1'b0;
        repeat (3) @(negedge clk);
        wlen = c; late = lt; rj = r; ws_pol = wp; sck_pol = sp;
        sck = ~sp;
        repeat (3) @(negedge clk);
        tx_en = 1'b1;
        glb_en = 1'b1;
    endtask

    task automatic t_reset();
        chk("R11 sd after reset", {31'd0, sd}, 32'd0);
        chk("R11 ready after reset", {31'd0, s_ready}, 32'd0);
        chk("R11 underflow after reset", {31'd0, uflow}, 32'd0);
    endtask

    task automatic t_lj(logic [1:0] c);
        logic [31:0] cap;
        int base;
        int n;
        n = wbits(c);
        setup(c, 1'b0, 1'b0, 1'b0, 1'b0);
        run_slot(1'b1, cap);
        chk("R9 slot before first frame is zero", cap, 32'd0);
        base = acc;
        for (int f = 0; f < 2; f++) begin
            run_slot(1'b0, cap);
            chk($sformatf("R1 R2 left code %0d", c), cap, exp_lj(n, lpat[(base + f) % 8]));
            run_slot(1'b1, cap);
            chk($sformatf("R1 R2 right code %0d", c), cap, exp_lj(n, rpat[(base + f) % 8]));
        end
        chk("R7 one pair per frame", acc - base, 2);
    endtask

    task automatic t_i2s(logic [1:0] c);
        logic [31:0] cap;
        logic        cy;
        int base;
        int n;
        n = wbits(c);
        setup(c, 1'b1, 1'b0, 1'b0, 1'b0);
        run_slot(1'b1, cap);
        base = acc;
        cy = 1'b0;
        for (int f = 0; f < 2; f++) begin
            run_slot(1'b0, cap);
            chk($sformatf("R3 left width %0d", n), cap, exp_i2s(n, lpat[(base + f) % 8], cy));
            cy = (n == 32) ? lpat[(base + f) % 8][0] : 1'b0;
            run_slot(1'b1, cap);
            chk($sformatf("R3 right width %0d", n), cap, exp_i2s(n, rpat[(base + f) % 8], cy));
            cy = (n == 32) ? rpat[(base + f) % 8][0] : 1'b0;
        end
    endtask

    task automatic t_rj();
        logic [31:0] cap;
        int base;
        setup(2'd1, 1'b1, 1'b1, 1'b0, 1'b0);
        run_slot(1'b1, cap);
        base = acc;
        run_slot(1'b0, cap);
        chk("R4 left right-justified 24", cap, trim(24, lpat[base % 8]));
        run_slot(1'b1, cap);
        chk("R4 right right-justified 24", cap, trim(24, rpat[base % 8]));
    endtask

    task automatic t_pol();
        logic [31:0] cap;
        int base;
        setup(2'd1, 1'b0, 1'b0, 1'b1, 1'b1);
        run_slot(1'b0, cap);
        base = acc;
        for (int f = 0; f < 2; f++) begin
            run_slot(1'b1, cap);
            chk("R5 R6 left with inverted polarities", cap, exp_lj(24, lpat[(base + f) % 8]));
            run_slot(1'b0, cap);
            chk("R5 R6 right with inverted polarities", cap, exp_lj(24, rpat[(base + f) % 8]));
        end
    endtask

    task automatic t_gate();
        logic [31:0] cap;
        int base;
        setup(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        glb_en = 1'b0;
        base = acc;
        run_slot(1'b1, cap);
        run_slot(1'b0, cap);
        chk("R9 global enable low: left silent", cap, 32'd0);
        run_slot(1'b1, cap);
        chk("R9 global enable low: right silent", cap, 32'd0);
        tx_en = 1'b0;
        glb_en = 1'b1;
        run_slot(1'b0, cap);
        chk("R9 tx enable low: left silent", cap, 32'd0);
        run_slot(1'b1, cap);
        chk("R9 no pair taken while gated", acc - base, 0);
    endtask

    task automatic t_underflow();
        logic [31:0] cap;
        int base;
        chk("R8 underflow clear before miss", {31'd0, uflow}, 32'd0);
        setup(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        s_valid = 1'b0;
        run_slot(1'b1, cap);
        base = acc;
        run_slot(1'b0, cap);
        chk("R8 missed pair: left zero", cap, 32'd0);
        run_slot(1'b1, cap);
        chk("R8 missed pair: right zero", cap, 32'd0);
        chk("R8 underflow set", {31'd0, uflow}, 32'd1);
        chk("R8 nothing accepted", acc - base, 0);
        s_valid = 1'b1;
        run_slot(1'b0, cap);
        chk("R8 data resumes", cap, exp_lj(16, lpat[base % 8]));
        run_slot(1'b1, cap);
        chk("R8 underflow sticky", {31'd0, uflow}, 32'd1);
    endtask

    task automatic t_midcfg();
        logic [31:0] cap;
        int base;
        setup(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        run_slot(1'b1, cap);
        base = acc;
        run_slot(1'b0, cap);
        chk("R10 left before change", cap, exp_lj(16, lpat[base % 8]));
        wlen = 2'd1;
        rj = 1'b1;
        run_slot(1'b1, cap);
        chk("R10 right keeps old format", cap, exp_lj(16, rpat[base % 8]));
        run_slot(1'b0, cap);
        chk("R10 next frame new format", cap, trim(24, lpat[(base + 1) % 8]));
        run_slot(1'b1, cap);
        chk("R10 next frame right new format", cap, trim(24, rpat[(base + 1) % 8]));
    endtask

    initial begin
        lpat[0] = 32'hDEAD_A5C3; rpat[0] = 32'h1234_5679;
        lpat[1] = 32'hFF80_0001; rpat[1] = 32'h0F0F_F00E;
        lpat[2] = 32'h8000_0001; rpat[2] = 32'h7FFF_FFFF;
        lpat[3] = 32'hABCD_EF13; rpat[3] = 32'hC0FF_EE00;
        lpat[4] = 32'h5555_AAAB; rpat[4] = 32'h9249_2493;
        lpat[5] = 32'h0000_8000; rpat[5] = 32'hFFFF_FFFF;
        lpat[6] = 32'h3C3C_C3C4; rpat[6] = 32'h0001_0001;
        lpat[7] = 32'hE7E7_1819; rpat[7] = 32'h8421_8421;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_lj(2'd0);
        t_lj(2'd1);
        t_lj(2'd2);
        t_lj(2'd3);
        t_i2s(2'd2);
        t_i2s(2'd0);
        t_rj();
        t_pol();
        t_gate();
        t_midcfg();
        t_underflow();
        finish_run();
    end

endmodule